// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

The block chooses one of two incoming reference clocks and forwards it on a single clock output. A configuration bit names which input is the primary; the other input is the backup. In manual operation a select pin chooses between primary and backup. In automatic operation the block watches the primary for activity, moves to the backup when the primary falls silent, and moves back once the primary has been running again for a while. Automatic operation is honoured only when input A is the primary. With input B as primary the block stays in manual operation.

Every change of source goes through a break-before-make handshake. Each input has its own enable, and that enable is resynchronised on the falling edge of its own clock. An enable may rise only after the other enable has been seen low. As a result the output never carries a pulse shorter than the shorter input half-period. The block also reports which input currently drives the output and whether the primary is considered lost.

Top module: `rcsw_switchover`

## Requirements
- R1: `prim_sel` = 0 makes input A the primary and `prim_sel` = 1 makes input B the primary. With manual operation and `man_sel` = 0, the primary drives the output, and `src_is_b` reads 1 exactly when input B is the driving source.
- R2: When `mode[1]` = 0 (mode values 2'b00 and 2'b01), operation is manual. `man_sel` = 0 picks the primary and `man_sel` = 1 picks the backup, and `pri_lost` stays 0.
- R3: When `mode[1]` = 1 (mode values 2'b10 and 2'b11) and `prim_sel` = 0, `man_sel` has no effect. If input A shows no transition across two full input-B cycles, `pri_lost` goes to 1 and the output moves to input B. The flag does not rise within 30 ns of input A stopping.
- R4: Automatic operation is revertive. After input A resumes, the block needs four consecutive activity indications from A, with no new loss among them. Only then does `pri_lost` return to 0 and the output move back to A. The flag is still 1 for at least 40 ns after A restarts.
- R5: With `mode[1]` = 1 and `prim_sel` = 1, the block behaves exactly as in manual operation. `pri_lost` stays 0 even while input A is stopped.
- R6: Both enables are never high at the same time, and an enable changes only while its own clock is low. On the output, every high and every low phase lasts at least the shorter input half-period.
- R7: If both input clocks stop, the selection is held, the output keeps its last level and `src_is_b` does not change.
- R8: `rst_n` is an active-low asynchronous reset. While it is low, `clk_out`, `src_is_b` and `pri_lost` are 0. After release, the source that is wanted takes over the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Reference clock input A |
| clk_b | input | 1 | Reference clock input B |
| rst_n | input | 1 | Active-low asynchronous reset |
| prim_sel | input | 1 | Primary choice: 0 = A, 1 = B |
| mode | input | 2 | Bit 1 set = automatic, clear = manual; bit 0 ignored |
| man_sel | input | 1 | Manual pick: 0 = primary, 1 = backup |
| clk_out | output | 1 | Selected, glitch-free clock |
| src_is_b | output | 1 | 1 while input B drives the output |
| pri_lost | output | 1 | 1 while the primary is considered absent (automatic only) |

## Verification
The bench keeps the default parameters: two-stage synchronisers, a loss window of two backup cycles and a recovery run of four. It drives A at 20 ns and B at 30 ns. With these values a stopped primary is detected within a few hundred nanoseconds, and the bench can probe the flag both inside the detection and recovery windows and after them. Because the two periods are unrelated, each handover phase is exercised for runt pulses through the measured minimum high and low widths on the output.

// File: rtl/rcsw_pkg.sv
package rcsw_pkg;
   localparam int unsigned NUM_SRC = 2;
   typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
endpackage

// File: rtl/rcsw_sync.sv
// Multi-stage resynchroniser; ON_FALL picks the capturing edge.
module rcsw_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          ON_FALL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   if (STAGES < 2) begin : g_bad_stages
      $error("rcsw_sync: STAGES must be at least 2");
   end

   if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
         if (!arst_n) pipe <= '0;
         else         pipe <= {pipe[STAGES-2:0], d};
      end
   end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) pipe <= '0;
         else         pipe <= {pipe[STAGES-2:0], d};
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/rcsw_activity_mon.sv
// Watches clk_watched from the clk_ref domain: a toggle carries activity
// across, idle reference edges count towards loss, a run of seen
// activity counts towards recovery.
module rcsw_activity_mon #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LOSS_CYC    = 2,
   parameter int unsigned RECOVER_CNT = 4
) (
   input  logic clk_watched,
   input  logic clk_ref,
   input  logic rst_n,
   output logic lost
);
   localparam int unsigned IDLE_W = $clog2(LOSS_CYC + 1);
   localparam int unsigned REC_W  = $clog2(RECOVER_CNT + 1);

   if (LOSS_CYC < 1 || RECOVER_CNT < 1) begin : g_bad_counts
      $error("rcsw_activity_mon: LOSS_CYC and RECOVER_CNT must be non-zero");
   end

   logic             tog_q, tog_s, tog_prev, seen_chg, lost_q;
   logic [IDLE_W-1:0] idle_cnt;
   logic [REC_W-1:0]  rec_cnt;

   always_ff @(posedge clk_watched or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;
   end

   rcsw_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b0)) u_tog_sync (
      .clk(clk_ref), .arst_n(rst_n), .d(tog_q), .q(tog_s)
   );

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) tog_prev <= 1'b0;
      else        tog_prev <= tog_s;
   end

   assign seen_chg = tog_s ^ tog_prev;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         rec_cnt  <= '0;
         lost_q   <= 1'b0;
      end else if (seen_chg) begin
         idle_cnt <= '0;
         if (lost_q) begin
            if (rec_cnt == REC_W'(RECOVER_CNT - 1)) begin
               lost_q  <= 1'b0;
               rec_cnt <= '0;
            end else begin
               rec_cnt <= rec_cnt + REC_W'(1);
            end
         end
      end else begin
         if (idle_cnt == IDLE_W'(LOSS_CYC - 1)) begin
            lost_q  <= 1'b1;
            rec_cnt <= '0;
         end
         if (idle_cnt != IDLE_W'(LOSS_CYC)) idle_cnt <= idle_cnt + IDLE_W'(1);
      end
   end

   assign lost = lost_q;

   // R3: loss is only declared at the end of an idle window
   assert_loss_after_idle_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(lost_q) |-> (!$past(seen_chg) && $past(idle_cnt) == IDLE_W'(LOSS_CYC - 1)));

   // R4: loss clears only on the last of a full activity run
   assert_revert_after_run_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(lost_q) |-> ($past(seen_chg) && $past(rec_cnt) == REC_W'(RECOVER_CNT - 1)));
endmodule

// File: rtl/rcsw_glitchfree_mux.sv
// Break-before-make clock multiplexer; each enable is resynchronised on
// the falling edge of its own clock and waits for the other to drop.
module rcsw_glitchfree_mux
   import rcsw_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic [NUM_SRC-1:0] clk_in,
   input  logic               rst_n,
   input  logic               sel_b,
   input  logic [NUM_SRC-1:0] kill,
   output logic               clk_out,
   output logic [NUM_SRC-1:0] en
);
   if (NUM_SRC != 2) begin : g_bad_src
      $error("rcsw_glitchfree_mux: exactly two sources are supported");
   end

   logic [NUM_SRC-1:0] req;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic arst_n_i;
      assign req[i]   = (sel_b == 1'(i)) && !en[1-i];
      assign arst_n_i = rst_n & ~kill[i];

      rcsw_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b1)) u_en_sync (
         .clk(clk_in[i]), .arst_n(arst_n_i), .d(req[i]), .q(en[i])
      );

      // R6: an enable moves only while its clock is low
      always @(en[i]) begin
         if (rst_n && !kill[i]) begin
            assert_gate_quiet_R6: assert (clk_in[i] == 1'b0)
               else $error("enable %0d changed while its clock was high", i);
         end
      end

      // R6: never two enables at once
      assert_enable_mutex_R6: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
         !(en[0] && en[1]));
   end

   assign clk_out = |(clk_in & en);
endmodule

// File: rtl/rcsw_switchover.sv
module rcsw_switchover
   import rcsw_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LOSS_CYC    = 2,
   parameter int unsigned RECOVER_CNT = 4
) (
   input  logic       clk_a,
   input  logic       clk_b,
   input  logic       rst_n,
   input  logic       prim_sel,
   input  logic [1:0] mode,
   input  logic       man_sel,
   output logic       clk_out,
   output logic       src_is_b,
   output logic       pri_lost
);
   logic               auto_en, mon_lost;
   logic               mode_lsb_unused;
   src_e               want_src;
   logic [NUM_SRC-1:0] en, kill;

   assign mode_lsb_unused = mode[0];
   // automatic operation only with input A as primary
   assign auto_en = mode[1] & ~prim_sel;

   rcsw_activity_mon #(
      .SYNC_STAGES(SYNC_STAGES), .LOSS_CYC(LOSS_CYC), .RECOVER_CNT(RECOVER_CNT)
   ) u_mon (
      .clk_watched(clk_a), .clk_ref(clk_b), .rst_n(rst_n), .lost(mon_lost)
   );

   always_comb begin
      if (auto_en) want_src = mon_lost ? SRC_B : SRC_A;
      else         want_src = src_e'(prim_sel ^ man_sel);
   end

   // a silent primary cannot clock its own enable down: clear it directly
   assign kill = {1'b0, auto_en & mon_lost};

   rcsw_glitchfree_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk_in({clk_b, clk_a}), .rst_n(rst_n), .sel_b(want_src == SRC_B),
      .kill(kill), .clk_out(clk_out), .en(en)
   );

   assign src_is_b = en[1];
   assign pri_lost = auto_en & mon_lost;
endmodule

// File: tb/rcsw_switchover_bench.sv
module rcsw_switchover_bench;
   logic       clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
   logic       prim_sel = 1'b0, man_sel = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       a_run = 1'b1, b_run = 1'b1;
   wire        clk_out, src_is_b, pri_lost;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   string tag_q[$];
   logic  src_q[$];
   logic  lost_q[$];
   event  chk_ev;

   realtime last_t = 0.0, w = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;
   bit      meas_en = 1'b0, fresh = 1'b1;
   int      n_edges = 0;
   logic    lvl;

   rcsw_switchover u_rcsw_switchover (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .prim_sel(prim_sel),
      .mode(mode), .man_sel(man_sel), .clk_out(clk_out),
      .src_is_b(src_is_b), .pri_lost(pri_lost)
   );

   // 50 MHz on input A, 30 ns on input B
   always begin #10; if (a_run) clk_a = ~clk_a; end
   always begin #15; if (b_run) clk_b = ~clk_b; end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_state(input string tag, input logic es, input logic el);
      tag_q.push_back(tag);
      src_q.push_back(es);
      lost_q.push_back(el);
      -> chk_ev;
   endtask

   // monitor side of the scoreboard
   initial forever begin
      @(chk_ev);
      while (tag_q.size() > 0) begin
         string t;
         logic  es, el;
         t  = tag_q.pop_front();
         es = src_q.pop_front();
         el = lost_q.pop_front();
         check(src_is_b === es, t, "src_is_b", int'(src_is_b), int'(es));
         check(pri_lost === el, t, "pri_lost", int'(pri_lost), int'(el));
      end
   end

   // output phase widths, for R6
   always @(clk_out) begin
      if (meas_en) begin
         if (!fresh) begin
            w = $realtime - last_t;
            if (clk_out) begin if (w < min_lo) min_lo = w; end
            else         begin if (w < min_hi) min_hi = w; end
         end
         last_t = $realtime;
         fresh  = 1'b0;
         n_edges++;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #53;
      // R8: reset state
      check(clk_out === 1'b0, "R8", "clk_out in reset", int'(clk_out), 0);
      expect_state("R8", 1'b0, 1'b0);
      rst_n = 1'b1;
      #300;
      fresh = 1'b1; meas_en = 1'b1;
      expect_state("R1", 1'b0, 1'b0);           // A primary drives
      man_sel = 1'b1; #300;
      expect_state("R2", 1'b1, 1'b0);           // backup B
      mode = 2'b01; man_sel = 1'b0; #300;
      expect_state("R2", 1'b0, 1'b0);           // 2'b01 still manual
      prim_sel = 1'b1; #300;
      expect_state("R1", 1'b1, 1'b0);           // B primary drives
      man_sel = 1'b1; #300;
      expect_state("R2", 1'b0, 1'b0);           // backup A
      // R5: automatic request with B primary stays manual
      mode = 2'b10; man_sel = 1'b0; #300;
      expect_state("R5", 1'b1, 1'b0);
      meas_en = 1'b0; a_run = 1'b0; #600;
      expect_state("R5", 1'b1, 1'b0);
      a_run = 1'b1; #600;
      // R3: automatic with A primary; man_sel ignored
      fresh = 1'b1; meas_en = 1'b1;
      prim_sel = 1'b0; man_sel = 1'b1; mode = 2'b11; #300;
      expect_state("R3", 1'b0, 1'b0);
      meas_en = 1'b0; a_run = 1'b0; #30;
      expect_state("R3", 1'b0, 1'b0);           // inside the loss window
      #600;
      expect_state("R3", 1'b1, 1'b1);
      a_run = 1'b1;
      fresh = 1'b1; meas_en = 1'b1;
      #40;
      expect_state("R4", 1'b1, 1'b1);           // recovery run not complete
      #600;
      expect_state("R4", 1'b0, 1'b0);           // reverted to A
      // R7: both clocks stop
      mode = 2'b00; man_sel = 1'b0; #300;
      meas_en = 1'b0; a_run = 1'b0; b_run = 1'b0; #40;
      lvl = clk_out;
      #500;
      check(clk_out === lvl, "R7", "clk_out held", int'(clk_out), int'(lvl));
      expect_state("R7", 1'b0, 1'b0);
      a_run = 1'b1; b_run = 1'b1; #300;
      fresh = 1'b1; meas_en = 1'b1;
      man_sel = 1'b1; #300;
      expect_state("R2", 1'b1, 1'b0);
      man_sel = 1'b0; prim_sel = 1'b1; #300;
      expect_state("R1", 1'b1, 1'b0);
      // R8: reset in mid-run, then wanted source B takes over
      meas_en = 1'b0;
      rst_n = 1'b0; #20;
      check(clk_out === 1'b0, "R8", "clk_out in reset", int'(clk_out), 0);
      expect_state("R8", 1'b0, 1'b0);
      rst_n = 1'b1; #300;
      expect_state("R8", 1'b1, 1'b0);
      // R6: no runt phases on the output
      check(min_hi >= 9.0, "R6", "min high ns", int'(min_hi), 10);
      check(min_lo >= 9.0, "R6", "min low ns", int'(min_lo), 10);
      check(n_edges > 50, "R6", "output edges", n_edges, 51);
      #10;
      finish_run();
   end
endmodule